// File: doc/BRIEF.md
# Disparity-Balanced 67-Bit Block Line Codec

This block turns a 64-bit payload word and a data/control indication into a 67-bit line block. Each block carries a two-bit sync header, a one-bit polarity flag and the payload. The encoder tracks the signed running disparity of everything it has sent. For each block it decides whether to send the payload bit-inverted, choosing whichever polarity stops the line from drifting further away from balance. The header is never inverted, so a receiver can always find it.

A companion decoder takes a 67-bit block, reads the header to tell data from control, flags headers that are not legal, and uses the polarity flag to return the payload with its original polarity. The encoder and decoder each have one registered stage. They sit in separate paths, so the decoder can be fed from the encoder (loopback) or from any other source of blocks. Scrambling, block alignment and lane handling belong to neighbouring blocks.

Top module: `blk67_codec`

## Requirements
- R1: An encoded block has its sync header in bits [66:65], with 2'b01 for data (`in_ctrl`=0) and 2'b10 for control (`in_ctrl`=1). The polarity flag is in bit [64] and the payload is in bits [63:0].
- R2: When the polarity flag is 1, bits [63:0] are the bitwise complement of the input word; when it is 0 they are the word unchanged. The header bits are never complemented.
- R3: The disparity of a block is its count of ones minus its count of zeros over all 67 bits. The running disparity starts at zero after reset and adds the disparity of each block actually sent.
- R4: The payload is sent complemented exactly when the running disparity is non-zero and has the same sign as the disparity the block would have if sent uncomplemented.
- R5: The magnitude of the running disparity never exceeds the payload width plus one (65 at the default width).
- R6: `enc_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. During idle cycles `enc_block` holds its last value and the running disparity does not change.
- R7: One cycle after `rx_valid`, `dec_valid` is high. `dec_data` holds bits [63:0] of the received block, complemented when bit [64] is 1. `dec_ctrl` is 1 exactly for header 2'b10.
- R8: A received header of 2'b00 or 2'b11 raises `dec_err` with `dec_valid`, with `dec_ctrl` low. The payload is still restored according to bit [64].
- R9: Synchronous active-high reset clears `enc_valid`, `enc_block`, `dec_valid`, `dec_data`, `dec_ctrl` and `dec_err` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload word present this cycle |
| in_data | input | 64 | Payload word to encode |
| in_ctrl | input | 1 | 1 = control block, 0 = data block |
| enc_valid | output | 1 | Encoded block valid |
| enc_block | output | 67 | Encoded line block |
| rx_valid | input | 1 | Received block present this cycle |
| rx_block | input | 67 | Received line block |
| dec_valid | output | 1 | Decoded word valid |
| dec_data | output | 64 | Payload with original polarity |
| dec_ctrl | output | 1 | Received block was a control block |
| dec_err | output | 1 | Received header was illegal |

## Verification
The bench builds the codec with its default 64-bit payload, which makes the disparity extremes exact. An all-ones word has uncomplemented disparity +63 and an all-zeros word has -65, the largest magnitude allowed. Repeated all-zeros words therefore drive the running disparity to the edge of its bound and force a complement on every other block. A word with 32 ones sits one step below balance and exercises the same-sign and opposite-sign decisions near zero.

// File: rtl/blk67_pkg.sv
package blk67_pkg;
  localparam int HDR_W  = 2;
  localparam int FLAG_W = 1;

  typedef enum logic [HDR_W-1:0] {
    HDR_BAD_LO = 2'b00,
    HDR_DATA   = 2'b01,
    HDR_CTRL   = 2'b10,
    HDR_BAD_HI = 2'b11
  } sync_hdr_e;
endpackage

// File: rtl/blk67_popcnt.sv
module blk67_popcnt #(
  parameter int W     = 64,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/blk67_encoder.sv
module blk67_encoder
  import blk67_pkg::*;
#(
  parameter int PAYLOAD_W = 64,
  localparam int BLOCK_W  = PAYLOAD_W + HDR_W + FLAG_W,
  localparam int CNT_W    = $clog2(PAYLOAD_W + 1),
  localparam int RD_W     = CNT_W + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [PAYLOAD_W-1:0]   in_data,
  input  logic                   in_ctrl,
  output logic                   enc_valid,
  output logic [BLOCK_W-1:0]     enc_block,
  output logic signed [RD_W-1:0] run_disp
);
  // Both legal headers carry exactly one '1', so the uncomplemented block
  // disparity is 2*(ones_in_payload + 1) - BLOCK_W.
  localparam logic signed [RD_W-1:0] BASE = RD_W'(2 - BLOCK_W);

  logic [CNT_W-1:0]        ones_pl;
  logic signed [RD_W-1:0]  disp_plain;
  logic signed [RD_W-1:0]  disp_sent;
  logic                    do_inv;
  sync_hdr_e               hdr;
  logic [PAYLOAD_W-1:0]    pl_out;

  blk67_popcnt #(.W(PAYLOAD_W), .CNT_W(CNT_W)) u_cnt (
    .vec   (in_data),
    .count (ones_pl)
  );

  always_comb begin
    disp_plain = $signed({{(RD_W-CNT_W-1){1'b0}}, ones_pl, 1'b0}) + BASE;
    do_inv     = (run_disp != '0) && (run_disp[RD_W-1] == disp_plain[RD_W-1]);
    disp_sent  = do_inv ? -disp_plain : disp_plain;
    hdr        = in_ctrl ? HDR_CTRL : HDR_DATA;
    pl_out     = do_inv ? ~in_data : in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid <= 1'b0;
      enc_block <= '0;
      run_disp  <= '0;
    end else begin
      enc_valid <= in_valid;
      if (in_valid) begin
        enc_block <= {hdr, do_inv, pl_out};
        run_disp  <= run_disp + disp_sent;
      end
    end
  end
endmodule

// File: rtl/blk67_decoder.sv
module blk67_decoder
  import blk67_pkg::*;
#(
  parameter int PAYLOAD_W = 64,
  localparam int BLOCK_W  = PAYLOAD_W + HDR_W + FLAG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic [BLOCK_W-1:0]   rx_block,
  output logic                 dec_valid,
  output logic [PAYLOAD_W-1:0] dec_data,
  output logic                 dec_ctrl,
  output logic                 dec_err
);
  sync_hdr_e            hdr;
  logic                 flag;
  logic [PAYLOAD_W-1:0] pl;

  always_comb begin
    hdr  = sync_hdr_e'(rx_block[BLOCK_W-1 -: HDR_W]);
    flag = rx_block[PAYLOAD_W];
    pl   = rx_block[PAYLOAD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_data  <= '0;
      dec_ctrl  <= 1'b0;
      dec_err   <= 1'b0;
    end else begin
      dec_valid <= rx_valid;
      dec_ctrl  <= rx_valid && (hdr == HDR_CTRL);
      dec_err   <= rx_valid && ((hdr == HDR_BAD_LO) || (hdr == HDR_BAD_HI));
      if (rx_valid) begin
        dec_data <= flag ? ~pl : pl;
      end
    end
  end
endmodule

// File: rtl/blk67_codec.sv
module blk67_codec
  import blk67_pkg::*;
#(
  parameter int PAYLOAD_W = 64,
  localparam int BLOCK_W  = PAYLOAD_W + HDR_W + FLAG_W,
  localparam int CNT_W    = $clog2(PAYLOAD_W + 1),
  localparam int RD_W     = CNT_W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [PAYLOAD_W-1:0] in_data,
  input  logic                 in_ctrl,
  output logic                 enc_valid,
  output logic [BLOCK_W-1:0]   enc_block,
  input  logic                 rx_valid,
  input  logic [BLOCK_W-1:0]   rx_block,
  output logic                 dec_valid,
  output logic [PAYLOAD_W-1:0] dec_data,
  output logic                 dec_ctrl,
  output logic                 dec_err
);
  logic signed [RD_W-1:0] enc_rd;

  blk67_encoder #(.PAYLOAD_W(PAYLOAD_W)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ctrl   (in_ctrl),
    .enc_valid (enc_valid),
    .enc_block (enc_block),
    .run_disp  (enc_rd)
  );

  blk67_decoder #(.PAYLOAD_W(PAYLOAD_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_block  (rx_block),
    .dec_valid (dec_valid),
    .dec_data  (dec_data),
    .dec_ctrl  (dec_ctrl),
    .dec_err   (dec_err)
  );
endmodule

// File: rtl/blk67_codec_chk.sv
module blk67_codec_chk #(
  parameter int PAYLOAD_W = 64,
  localparam int BLOCK_W  = PAYLOAD_W + 3,
  localparam int CNT_W    = $clog2(PAYLOAD_W + 1),
  localparam int RD_W     = CNT_W + 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [PAYLOAD_W-1:0]   in_data,
  input logic                   in_ctrl,
  input logic                   enc_valid,
  input logic [BLOCK_W-1:0]     enc_block,
  input logic                   rx_valid,
  input logic [BLOCK_W-1:0]     rx_block,
  input logic                   dec_valid,
  input logic                   dec_err,
  input logic                   dec_ctrl,
  input logic signed [RD_W-1:0] enc_rd
);
  localparam logic signed [RD_W-1:0] BOUND = RD_W'(PAYLOAD_W + 1);

  p_hdr_r1: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> enc_block[BLOCK_W-1 -: 2] == ($past(in_ctrl) ? 2'b10 : 2'b01));

  p_payload_r2: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (enc_block[PAYLOAD_W-1:0] ^ {PAYLOAD_W{enc_block[PAYLOAD_W]}}) == $past(in_data));

  p_toward_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(enc_rd) > 0) |-> enc_rd < $past(enc_rd));

  p_rd_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (enc_rd <= BOUND) && (enc_rd >= -BOUND));

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> enc_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !enc_valid && $stable(enc_rd) && $stable(enc_block));

  p_err_hdr_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> dec_err == ($past(rx_block[BLOCK_W-1]) == $past(rx_block[BLOCK_W-2])));

  p_err_ctrl_r8: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> dec_valid && !dec_ctrl);
endmodule

bind blk67_codec blk67_codec_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ctrl   (in_ctrl),
  .enc_valid (enc_valid),
  .enc_block (enc_block),
  .rx_valid  (rx_valid),
  .rx_block  (rx_block),
  .dec_valid (dec_valid),
  .dec_err   (dec_err),
  .dec_ctrl  (dec_ctrl),
  .enc_rd    (enc_rd)
);

// File: tb/blk67_codec_test.sv
module blk67_codec_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 64;
  localparam int BW = PW + 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [PW-1:0] in_data;
  logic          in_ctrl;
  logic          enc_valid;
  logic [BW-1:0] enc_block;
  logic          rx_valid;
  logic [BW-1:0] rx_block;
  logic          dec_valid;
  logic [PW-1:0] dec_data;
  logic          dec_ctrl;
  logic          dec_err;

  int n_chk = 0;
  int n_bad = 0;
  int model_rd = 0;
  int seen_rd  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk67_codec #(.PAYLOAD_W(PW)) uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl),
    .enc_valid(enc_valid), .enc_block(enc_block),
    .rx_valid(rx_valid), .rx_block(rx_block),
    .dec_valid(dec_valid), .dec_data(dec_data),
    .dec_ctrl(dec_ctrl), .dec_err(dec_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Push one word (caller is at a negedge); check the block one cycle later.
  task automatic push(input logic [PW-1:0] d, input logic c);
    int du;
    bit inv;
    logic [BW-1:0] exp;
    du  = 2 * (1 + $countones(d)) - BW;
    inv = (model_rd != 0) && ((model_rd > 0) == (du > 0));
    exp = {(c ? 2'b10 : 2'b01), inv, (inv ? ~d : d)};
    model_rd += inv ? -du : du;
    in_valid = 1'b1; in_data = d; in_ctrl = c;
    @(negedge clk);
    check(enc_valid === 1'b1, "R6", "enc_valid after push", BW'(enc_valid), BW'(1));
    check(enc_block === exp, "R4", "encoded block", enc_block, exp);
    seen_rd += 2 * $countones(enc_block) - BW;
    check(seen_rd == model_rd, "R3", "running disparity", BW'(seen_rd), BW'(model_rd));
    check(seen_rd <= PW + 1 && seen_rd >= -(PW + 1), "R5", "disparity bound",
          BW'(seen_rd), BW'(PW + 1));
  endtask

  task automatic idle();
    logic [BW-1:0] held;
    held = enc_block;
    in_valid = 1'b0;
    @(negedge clk);
    check(enc_valid === 1'b0, "R6", "enc_valid idle", BW'(enc_valid), '0);
    check(enc_block === held, "R6", "block held idle", enc_block, held);
  endtask

  task automatic rx(input logic [BW-1:0] b, input logic [PW-1:0] exp_d,
                    input logic exp_c, input logic exp_e, input string req);
    rx_valid = 1'b1; rx_block = b;
    @(negedge clk);
    rx_valid = 1'b0;
    check(dec_valid === 1'b1, req, "dec_valid", BW'(dec_valid), BW'(1));
    check(dec_data === exp_d, req, "dec_data", BW'(dec_data), BW'(exp_d));
    check(dec_ctrl === exp_c, req, "dec_ctrl", BW'(dec_ctrl), BW'(exp_c));
    check(dec_err === exp_e, req, "dec_err", BW'(dec_err), BW'(exp_e));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_ctrl = 1'b0;
    rx_valid = 1'b0; rx_block = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(enc_valid === 1'b0 && enc_block === '0, "R9", "encoder reset", enc_block, '0);
    check(dec_valid === 1'b0 && dec_data === '0 && dec_ctrl === 1'b0 && dec_err === 1'b0,
          "R9", "decoder reset", BW'(dec_data), '0);
  endtask

  task automatic t_layout_r1();
    push(64'h0123_4567_89AB_CDEF, 1'b0);
    check(enc_block[66:65] === 2'b01, "R1", "data header", BW'(enc_block[66:65]), BW'(2'b01));
    push(64'h0000_0000_FFFF_0000, 1'b1);
    check(enc_block[66:65] === 2'b10, "R1", "ctrl header", BW'(enc_block[66:65]), BW'(2'b10));
    idle();
  endtask

  task automatic t_extremes_r4();
    // all ones: +63 plain; all zeros: -65 plain
    for (int i = 0; i < 4; i++) push('1, 1'b0);
    for (int i = 0; i < 5; i++) push('0, 1'b0);
    idle();
    for (int i = 0; i < 3; i++) push('0, 1'b1);
    push({32{2'b10}}, 1'b0);
    push({32{2'b01}}, 1'b0);
    idle();
    idle();
  endtask

  task automatic t_pattern_r2();
    logic [PW-1:0] w;
    w = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 20; i++) begin
      push(w, i[0]);
      check((enc_block[63:0] ^ {64{enc_block[64]}}) === w, "R2", "payload polarity",
            BW'(enc_block[63:0] ^ {64{enc_block[64]}}), BW'(w));
      w = {w[62:0], w[63] ^ w[62] ^ w[60] ^ w[59]} + 64'h1F;
    end
    idle();
  endtask

  task automatic t_loopback_r7();
    logic [PW-1:0] words [4];
    words[0] = '1; words[1] = 64'hDEAD_BEEF_0000_0001; words[2] = '0; words[3] = '1;
    for (int i = 0; i < 4; i++) begin
      push(words[i], i[0]);
      in_valid = 1'b0;
      rx(enc_block, words[i], i[0], 1'b0, "R7");
    end
    rx({2'b10, 1'b1, 64'h00FF_00FF_00FF_00FF}, 64'hFF00_FF00_FF00_FF00, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_bad_hdr_r8();
    rx({2'b00, 1'b0, 64'h1234_5678_9ABC_DEF0}, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, "R8");
    rx({2'b11, 1'b1, 64'h1234_5678_9ABC_DEF0}, ~64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, "R8");
    @(negedge clk);
    check(dec_valid === 1'b0 && dec_err === 1'b0, "R8", "err clears when idle",
          BW'(dec_err), '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_layout_r1();
    t_extremes_r4();
    t_pattern_r2();
    t_loopback_r7();
    t_bad_hdr_r8();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule